// File: doc/BRIEF.md
# Converter Power-State and Conversion-Clock Controller

This block keeps the operating state of a serial successive-approximation converter. It decides whether the analog core is fully on, idling with only the reference buffer alive, or shut down. It decides whether conversions are timed by the serial clock or by an on-chip oscillator. When the on-chip oscillator is selected, it also runs each conversion. Every decoded control byte delivers a two-bit power/clock code, and the serial front end reports each start bit with a one-cycle strobe.

In oscillator-timed mode the block counts oscillator ticks through an acquisition window and then a conversion window. During that time it holds a busy strobe low. When the conversion finishes it pulses a load into the result register. A power-down requested in software waits until the running conversion is finished. The shutdown pin acts at once and cancels any conversion. The next start bit brings the device back to full operation. The serial side stays active in every state, so a stored result can still be read.

Top module: `pdc_ctrl`

## Requirements
- R1: After reset the block is in normal operation with oscillator timing selected (`clk_ext_sel`=0). `sstrb_int` is high, `res_load` is low, and both `analog_en` and `ref_buf_en` are high.
- R2: A control byte carries the code `cfg_pd`. Code 2'b00 selects oscillator timing and code 2'b01 selects serial-clock timing. Codes 2'b10 and 2'b11 leave the timing selection as it was.
- R3: A control byte that leaves oscillator timing selected starts a conversion, and `sstrb_int` is low from the next cycle. `track_en` is high for the first 4 oscillator ticks and `conv_en` is high for the next 12 ticks. On the edge that takes the 16th tick, `sstrb_int` returns high and `res_load` pulses for exactly one cycle.
- R4: While `shdn_n` is low, the state is full power-down from the next cycle. Any conversion is dropped with no `res_load`, and start strobes and control bytes are ignored. After `shdn_n` rises, the state stays full power-down until a start strobe arrives.
- R5: Code 2'b10 requests standby and code 2'b11 requests full power-down. The request takes effect on the first edge at which no oscillator-timed conversion is running and `ext_busy` is low. If neither is active, that edge is the one after the control byte.
- R6: A start strobe with `shdn_n` high puts the block in normal operation from the next cycle and cancels any pending software power-down.
- R7: Exactly one of `pwr_normal`, `pwr_standby` and `pwr_full` is high. `analog_en` is high only in normal operation. `ref_buf_en` is high in normal operation and in standby.
- R8: `sstrb_drive` is high whenever oscillator timing is selected, in every power state, and low when serial-clock timing is selected.
- R9: A control byte that selects or keeps serial-clock timing starts no oscillator-timed conversion, so `sstrb_int` stays high.
- R10: Oscillator ticks while no conversion is running have no effect. `res_load` stays low and `sstrb_int` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| shdn_n | input | 1 | Active-low hardware shutdown |
| start_det | input | 1 | One-cycle strobe for a detected start bit |
| cfg_valid | input | 1 | One-cycle strobe for a complete control byte |
| cfg_pd | input | 2 | Power/clock code of that control byte |
| osc_tick | input | 1 | One-cycle tick from the on-chip oscillator |
| ext_busy | input | 1 | A serial-clock-timed conversion is in progress |
| pwr_normal | output | 1 | Normal operation |
| pwr_standby | output | 1 | Standby power-down |
| pwr_full | output | 1 | Full power-down |
| clk_ext_sel | output | 1 | 1 = serial-clock timing, 0 = oscillator timing |
| sstrb_int | output | 1 | Busy strobe for oscillator-timed mode, low while converting |
| sstrb_drive | output | 1 | Drive enable for the strobe pin in oscillator-timed mode |
| track_en | output | 1 | Acquisition window active |
| conv_en | output | 1 | Bit-decision window active |
| res_load | output | 1 | Load pulse for the result register |
| analog_en | output | 1 | Enable for the analog core |
| ref_buf_en | output | 1 | Enable for the reference buffer |

## Verification
The bound checker checks the following on every cycle:
- exactly one power state is active;
- the shutdown pin forces full power-down and cancels the conversion;
- full power-down is left only through a start strobe;
- a software request never removes power while a conversion is running;
- power-down codes do not change the timing selection;
- an idle block never produces a load pulse.

Only the bench scenarios can show the exact tick counts of the two windows, the code-by-code decoding, and where the deferred power-down lands. The same applies to a start strobe cancelling a pending request and to the deferral while `ext_busy` is held.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    PWR_NORM = 2'd0,
    PWR_STBY = 2'd1,
    PWR_FULL = 2'd2
  } pwr_e;

  localparam logic [1:0] PD_OSC  = 2'b00;
  localparam logic [1:0] PD_SER  = 2'b01;
  localparam logic [1:0] PD_STBY = 2'b10;
  localparam logic [1:0] PD_FULL = 2'b11;

  // timing selection after a control byte: sleep codes keep the current one
  function automatic logic pd_next_ext(input logic [1:0] pd, input logic cur_ext);
    return pd[1] ? cur_ext : pd[0];
  endfunction

  function automatic logic pd_is_sleep(input logic [1:0] pd);
    return pd[1];
  endfunction

  function automatic pwr_e pd_sleep_target(input logic [1:0] pd);
    return pd[0] ? PWR_FULL : PWR_STBY;
  endfunction

endpackage

// File: rtl/pdc_int_seq.sv
module pdc_int_seq #(
  parameter int ACQ_TICKS  = 4,
  parameter int CONV_TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic busy,
  output logic in_acq,
  output logic in_conv,
  output logic done_q
);
  localparam int TOTAL = ACQ_TICKS + CONV_TICKS;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] ACQ_END = CNT_W'(ACQ_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = busy && tick && (cnt_q == LAST);
  assign in_acq    = busy && (cnt_q < ACQ_END);
  assign in_conv   = busy && (cnt_q >= ACQ_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (last_tick) begin
        busy   <= 1'b0;
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else if (busy && tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdc_mode_reg.sv
module pdc_mode_reg
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       start_det,
  input  logic       cfg_valid,
  input  logic [1:0] cfg_pd,
  input  logic       conv_busy,
  output pwr_e       pwr,
  output logic       clk_ext,
  output logic       sleep_apply
);
  logic pend_q;
  pwr_e pend_tgt_q;

  assign sleep_apply = shdn_n && pend_q && !conv_busy && !cfg_valid && !start_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr        <= PWR_NORM;
      clk_ext    <= 1'b0;
      pend_q     <= 1'b0;
      pend_tgt_q <= PWR_STBY;
    end else if (!shdn_n) begin
      pwr    <= PWR_FULL;
      pend_q <= 1'b0;
    end else begin
      if (start_det) begin
        pwr    <= PWR_NORM;
        pend_q <= 1'b0;
      end
      if (cfg_valid) begin
        clk_ext    <= pd_next_ext(cfg_pd, clk_ext);
        pend_q     <= pd_is_sleep(cfg_pd);
        pend_tgt_q <= pd_sleep_target(cfg_pd);
      end else if (sleep_apply) begin
        pwr    <= pend_tgt_q;
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int ACQ_TICKS  = 4,
  parameter int CONV_TICKS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       start_det,
  input  logic       cfg_valid,
  input  logic [1:0] cfg_pd,
  input  logic       osc_tick,
  input  logic       ext_busy,
  output logic       pwr_normal,
  output logic       pwr_standby,
  output logic       pwr_full,
  output logic       clk_ext_sel,
  output logic       sstrb_int,
  output logic       sstrb_drive,
  output logic       track_en,
  output logic       conv_en,
  output logic       res_load,
  output logic       analog_en,
  output logic       ref_buf_en
);
  pwr_e pwr;
  logic clk_ext;
  logic sleep_apply;
  logic seq_busy;
  logic seq_start;
  logic seq_abort;
  logic conv_busy;

  assign seq_abort = !shdn_n;
  assign seq_start = shdn_n && cfg_valid && !pd_next_ext(cfg_pd, clk_ext);
  assign conv_busy = seq_busy || ext_busy;

  pdc_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_n     (shdn_n),
    .start_det  (start_det),
    .cfg_valid  (cfg_valid),
    .cfg_pd     (cfg_pd),
    .conv_busy  (conv_busy),
    .pwr        (pwr),
    .clk_ext    (clk_ext),
    .sleep_apply(sleep_apply)
  );

  pdc_int_seq #(
    .ACQ_TICKS (ACQ_TICKS),
    .CONV_TICKS(CONV_TICKS)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_start),
    .abort  (seq_abort),
    .tick   (osc_tick),
    .busy   (seq_busy),
    .in_acq (track_en),
    .in_conv(conv_en),
    .done_q (res_load)
  );

  assign pwr_normal  = (pwr == PWR_NORM);
  assign pwr_standby = (pwr == PWR_STBY);
  assign pwr_full    = (pwr == PWR_FULL);
  assign clk_ext_sel = clk_ext;
  assign sstrb_int   = !seq_busy;
  assign sstrb_drive = !clk_ext;
  assign analog_en   = pwr_normal;
  assign ref_buf_en  = !pwr_full;
endmodule

// File: rtl/pdc_ctrl_chk.sv
module pdc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       shdn_n,
  input logic       start_det,
  input logic       cfg_valid,
  input logic [1:0] cfg_pd,
  input logic       ext_busy,
  input logic       pwr_normal,
  input logic       pwr_standby,
  input logic       pwr_full,
  input logic       clk_ext_sel,
  input logic       sstrb_int,
  input logic       track_en,
  input logic       conv_en,
  input logic       res_load
);
  p_onehot_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pwr_normal, pwr_standby, pwr_full}) == 1);

  p_shdn_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> pwr_full && sstrb_int && !res_load);

  p_full_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_full && !(start_det && shdn_n) |=> pwr_full);

  p_defer_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n && pwr_normal && (!sstrb_int || ext_busy) |=> pwr_normal);

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n && start_det |=> pwr_normal);

  p_keep_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n && cfg_valid && cfg_pd[1] |=> $stable(clk_ext_sel));

  p_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> !track_en && !sstrb_int);

  p_idle_noload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sstrb_int |=> !res_load);

  p_ser_noseq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n && cfg_valid && cfg_pd == 2'b01 && sstrb_int |=> sstrb_int);
endmodule

bind pdc_ctrl pdc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shdn_n     (shdn_n),
  .start_det  (start_det),
  .cfg_valid  (cfg_valid),
  .cfg_pd     (cfg_pd),
  .ext_busy   (ext_busy),
  .pwr_normal (pwr_normal),
  .pwr_standby(pwr_standby),
  .pwr_full   (pwr_full),
  .clk_ext_sel(clk_ext_sel),
  .sstrb_int  (sstrb_int),
  .track_en   (track_en),
  .conv_en    (conv_en),
  .res_load   (res_load)
);

// File: tb/pdc_ctrl_bench.sv
module pdc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n, shdn_n, start_det, cfg_valid, osc_tick, ext_busy;
  logic [1:0] cfg_pd;
  logic pwr_normal, pwr_standby, pwr_full, clk_ext_sel, sstrb_int, sstrb_drive;
  logic track_en, conv_en, res_load, analog_en, ref_buf_en;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  pdc_ctrl u_pdc_ctrl (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .start_det(start_det),
    .cfg_valid(cfg_valid), .cfg_pd(cfg_pd), .osc_tick(osc_tick), .ext_busy(ext_busy),
    .pwr_normal(pwr_normal), .pwr_standby(pwr_standby), .pwr_full(pwr_full),
    .clk_ext_sel(clk_ext_sel), .sstrb_int(sstrb_int), .sstrb_drive(sstrb_drive),
    .track_en(track_en), .conv_en(conv_en), .res_load(res_load),
    .analog_en(analog_en), .ref_buf_en(ref_buf_en)
  );

  // {code[1:0], expected serial-clock timing, expected state (0 normal, 1 standby, 2 full)}
  localparam logic [4:0] VEC [0:7] = '{
    {2'b00, 1'b0, 2'd0}, {2'b01, 1'b1, 2'd0}, {2'b10, 1'b1, 2'd1}, {2'b00, 1'b0, 2'd0},
    {2'b11, 1'b0, 2'd2}, {2'b10, 1'b0, 2'd1}, {2'b01, 1'b1, 2'd0}, {2'b11, 1'b1, 2'd2}
  };

  function automatic int obs_state();
    return pwr_full ? 2 : (pwr_standby ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      osc_tick = 1'b1; step(); osc_tick = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [1:0] pd);
    start_det = 1'b1; step(); start_det = 1'b0;
    chk(pwr_normal == 1'b1, "R6", pwr_normal, 1);
    step(); step();
    cfg_pd = pd; cfg_valid = 1'b1; step(); cfg_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; shdn_n = 1'b1; start_det = 1'b0; cfg_valid = 1'b0;
    cfg_pd = 2'b00; osc_tick = 1'b0; ext_busy = 1'b0;
    repeat (3) step();
    rst_n = 1'b1; step();
    // R1 reset state
    chk(pwr_normal == 1'b1, "R1", pwr_normal, 1);
    chk(clk_ext_sel == 1'b0, "R1", clk_ext_sel, 0);
    chk(sstrb_int == 1'b1, "R1", sstrb_int, 1);
    chk(res_load == 1'b0, "R1", res_load, 0);
    chk(analog_en && ref_buf_en, "R1", analog_en, 1);
    chk(sstrb_drive == 1'b1, "R8", sstrb_drive, 1);
    // R10 idle ticks
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk(res_load == 1'b0 && sstrb_int == 1'b1, "R10", res_load, 0);
    end

    // table walk: decoding, conversion timing, deferred power-down
    for (int i = 0; i < 8; i++) begin
      logic [1:0] pd;
      logic       e_ext;
      int         e_st;
      pd = VEC[i][4:3]; e_ext = VEC[i][2]; e_st = int'(VEC[i][1:0]);
      send_byte(pd);
      if (!e_ext) begin
        chk(sstrb_int == 1'b0, "R3", sstrb_int, 0);
        chk(track_en == 1'b1, "R3", track_en, 1);
        tick(3);
        chk(track_en == 1'b1 && conv_en == 1'b0, "R3", track_en, 1);
        tick(1);
        chk(conv_en == 1'b1 && track_en == 1'b0, "R3", conv_en, 1);
        tick(11);
        chk(pwr_normal == 1'b1, "R5", obs_state(), 0);
        chk(sstrb_int == 1'b0 && res_load == 1'b0, "R3", sstrb_int, 0);
        tick(1);
        chk(res_load == 1'b1, "R3", res_load, 1);
        chk(sstrb_int == 1'b1, "R3", sstrb_int, 1);
        step();
        chk(res_load == 1'b0, "R3", res_load, 0);
      end else begin
        chk(sstrb_int == 1'b1, "R9", sstrb_int, 1);
        step();
      end
      chk(clk_ext_sel == e_ext, "R2", clk_ext_sel, e_ext);
      chk(obs_state() == e_st, "R5", obs_state(), e_st);
      chk(sstrb_drive == !e_ext, "R8", sstrb_drive, !e_ext);
      chk(analog_en == (e_st == 0), "R7", analog_en, e_st == 0);
      chk(ref_buf_en == (e_st != 2), "R7", ref_buf_en, e_st != 2);
    end

    // R4 shutdown aborts a running conversion
    send_byte(2'b00);
    tick(6);
    shdn_n = 1'b0; step();
    chk(pwr_full == 1'b1, "R4", obs_state(), 2);
    chk(sstrb_int == 1'b1 && conv_en == 1'b0, "R4", sstrb_int, 1);
    for (int k = 0; k < 12; k++) begin
      tick(1);
      chk(res_load == 1'b0, "R4", res_load, 0);
    end
    start_det = 1'b1; step(); start_det = 1'b0;
    chk(pwr_full == 1'b1, "R4", obs_state(), 2);
    cfg_pd = 2'b00; cfg_valid = 1'b1; step(); cfg_valid = 1'b0;
    chk(sstrb_int == 1'b1, "R4", sstrb_int, 1);
    shdn_n = 1'b1; step(); step();
    chk(pwr_full == 1'b1, "R4", obs_state(), 2);
    start_det = 1'b1; step(); start_det = 1'b0;
    chk(pwr_normal == 1'b1, "R6", obs_state(), 0);

    // R6 a start strobe cancels a pending power-down
    send_byte(2'b11);
    tick(3);
    start_det = 1'b1; step(); start_det = 1'b0;
    tick(13);
    chk(res_load == 1'b1, "R3", res_load, 1);
    step(); step();
    chk(pwr_normal == 1'b1, "R6", obs_state(), 0);

    // R5 deferral while a serial-clock conversion runs
    send_byte(2'b01);
    step();
    start_det = 1'b1; step(); start_det = 1'b0;
    step();
    cfg_pd = 2'b10; cfg_valid = 1'b1; ext_busy = 1'b1; step(); cfg_valid = 1'b0;
    repeat (4) step();
    chk(pwr_normal == 1'b1, "R5", obs_state(), 0);
    chk(sstrb_int == 1'b1, "R9", sstrb_int, 1);
    ext_busy = 1'b0; step();
    chk(pwr_standby == 1'b1, "R5", obs_state(), 1);
    chk(sstrb_drive == 1'b0, "R8", sstrb_drive, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule